// File: doc/BRIEF.md
# Unaligned Packet Length Meter

This block watches a wide packet stream in which a packet may begin at a coarse offset inside a bus word and may end at any byte of a word. For every packet that completes, it reports the packet's byte count on a registered output together with a one-cycle valid strobe. It is a passive observer. It receives both handshake signals as inputs and never drives the ready signal. It ignores the payload, because the length depends only on where each packet starts and where it ends.

Three parameters set the bus width, the width of the start-position field and the width of the length result. The start position selects one of 2^POS_W equal slices of the word. Byte 0 is the least significant byte of the bus. The end position is a byte index into the word. A single word may hold a whole packet. A single word may also hold the tail of one packet and the head of the next.

Top module: `pkt_len_meter`

## Requirements
- R1: A word counts only in a cycle where both `in_src_rdy` and `in_dst_rdy` are 1. Any other cycle changes no state and produces no strobe.
- R2: A packet's first word contributes BUS_W/8 - `in_sop_pos`*(BUS_W/8)/2^POS_W bytes. With the default 512-bit bus and start index 2, that is 48 bytes.
- R3: An accepted word inside an open packet that has neither start nor end adds BUS_W/8 bytes (64 at the default width).
- R4: The final word adds `in_eop_pos`+1 bytes. `len_vld` is 1 for exactly one cycle, in the cycle after that word is accepted, and `len_out` then holds the total. For example, 48+64+13 gives 125.
- R5: Suppose a word carries both start and end, and `in_eop_pos` is not below the scaled start offset. That word is one whole packet, and its length is `in_eop_pos`+1 minus the offset. For example, start index 1 and end index 20 give 13.
- R6: Suppose a word carries both start and end, `in_eop_pos` is below the scaled start offset, and a packet is open. The open packet is closed with `in_eop_pos`+1 added, and a new packet opens with its first-word count. For example, end index 12 and start index 2 report 125, then 48+32=80 for the next packet.
- R7: An accepted end word with no open packet and no start produces no strobe. An accepted word with neither start nor end outside a packet adds nothing.
- R8: While `rst_n` is 0, `len_vld` stays 0. Reset also discards any open packet, so an end word that follows reset produces no strobe.
- R9: `len_vld` falls back to 0 in the cycle after the strobe unless another packet ended in the word accepted just before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_src_rdy | input | 1 | Source has a word on the bus |
| in_dst_rdy | input | 1 | Sink accepts the word |
| in_sop | input | 1 | A packet starts in this word |
| in_sop_pos | input | POS_W | Start slice index |
| in_eop | input | 1 | A packet ends in this word |
| in_eop_pos | input | log2(BUS_W/8) | Byte index of the last packet byte |
| len_out | output | LEN_W | Length of the packet just finished |
| len_vld | output | 1 | One-cycle strobe qualifying `len_out` |

## Verification
Closing one packet and opening the next can both happen in the same accepted word. The bench provokes this with end index 12 and start index 2, and also with end index 7 and start index 1 at the slice boundary. It judges the case by two results. The strobe in the following cycle must carry the old packet's full total. The next packet's reported length must then start from the new first-word count, not from any leftover of the old sum. A same-word start and end that does not overlap is also driven, to show that it is treated as one short packet instead.

// File: rtl/pkt_len_meter.sv
module pkt_len_meter #(
  parameter int BUS_W = 512,
  parameter int POS_W = 3,
  parameter int LEN_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_src_rdy,
  input  logic                         in_dst_rdy,
  input  logic                         in_sop,
  input  logic [POS_W-1:0]             in_sop_pos,
  input  logic                         in_eop,
  input  logic [$clog2(BUS_W/8)-1:0]   in_eop_pos,
  output logic [LEN_W-1:0]             len_out,
  output logic                         len_vld
);
  localparam int BYTES = BUS_W / 8;
  localparam int STEP  = BYTES >> POS_W;

  logic             xfer, open_q, split;
  logic [LEN_W-1:0] start_off, first_cnt, last_cnt, acc;

  assign xfer      = in_src_rdy && in_dst_rdy;
  assign start_off = LEN_W'(in_sop_pos) * LEN_W'(STEP);
  assign first_cnt = LEN_W'(BYTES) - start_off;
  assign last_cnt  = LEN_W'(in_eop_pos) + LEN_W'(1);
  assign split     = last_cnt <= start_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      open_q  <= 1'b0;
      len_out <= '0;
      len_vld <= 1'b0;
    end else begin
      len_vld <= 1'b0;
      if (xfer) begin
        if (in_sop && in_eop && !split) begin
          len_out <= last_cnt - start_off;
          len_vld <= 1'b1;
          open_q  <= 1'b0;
        end else begin
          if (in_eop && open_q) begin
            len_out <= acc + last_cnt;
            len_vld <= 1'b1;
          end
          if (in_sop) begin
            acc    <= first_cnt;
            open_q <= 1'b1;
          end else if (in_eop) begin
            open_q <= 1'b0;
          end else if (open_q) begin
            acc <= acc + LEN_W'(BYTES);
          end
        end
      end
    end
  end
endmodule

// File: rtl/pkt_len_meter_chk.sv
module pkt_len_meter_chk #(
  parameter int BUS_W = 512,
  parameter int POS_W = 3,
  parameter int LEN_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_src_rdy,
  input logic                       in_dst_rdy,
  input logic                       in_sop,
  input logic [POS_W-1:0]           in_sop_pos,
  input logic                       in_eop,
  input logic [$clog2(BUS_W/8)-1:0] in_eop_pos,
  input logic [LEN_W-1:0]           len_out,
  input logic                       len_vld,
  input logic                       open_q
);
  localparam int SLICE = (BUS_W / 8) >> POS_W;

  logic             acc_word;
  logic [LEN_W-1:0] off_b, end_b;
  assign acc_word = in_src_rdy && in_dst_rdy;
  assign off_b    = LEN_W'(in_sop_pos) * LEN_W'(SLICE);
  assign end_b    = LEN_W'(in_eop_pos);

  // R4
  vld_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_vld |-> $past(acc_word && in_eop));

  // R1
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_word |=> !len_vld);

  // R5
  single_word_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_word && in_sop && in_eop && end_b >= off_b)
      |=> (len_vld && len_out == $past(end_b + LEN_W'(1) - off_b)));

  // R6
  split_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_word && in_sop && in_eop && end_b < off_b) |=> open_q);

  // R7
  orphan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_word && in_eop && !in_sop && !open_q) |=> !len_vld);

  // R8
  always @(posedge clk) if (!rst_n) reset_quiet_chk: assert (!len_vld);
endmodule

bind pkt_len_meter pkt_len_meter_chk #(.BUS_W(BUS_W), .POS_W(POS_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_src_rdy(in_src_rdy), .in_dst_rdy(in_dst_rdy),
  .in_sop(in_sop), .in_sop_pos(in_sop_pos), .in_eop(in_eop), .in_eop_pos(in_eop_pos),
  .len_out(len_out), .len_vld(len_vld), .open_q(open_q)
);

// File: tb/test_pkt_len_meter.sv
module test_pkt_len_meter;
  localparam int BUS_W = 512, POS_W = 3, LEN_W = 16;
  localparam int EW = $clog2(BUS_W/8);
  localparam int NV = 17;

  logic clk = 0, rst_n = 0;
  logic src = 0, dst = 0, sop = 0, eop = 0;
  logic [POS_W-1:0] sp = '0;
  logic [EW-1:0] ep = '0;
  logic [LEN_W-1:0] len_out;
  logic len_vld;
  int runs = 0, fails = 0;

  always #5 clk = ~clk;

  pkt_len_meter #(.BUS_W(BUS_W), .POS_W(POS_W), .LEN_W(LEN_W)) i_pkt_len_meter (
    .clk(clk), .rst_n(rst_n), .in_src_rdy(src), .in_dst_rdy(dst), .in_sop(sop),
    .in_sop_pos(sp), .in_eop(eop), .in_eop_pos(ep), .len_out(len_out), .len_vld(len_vld));

  // {src, dst, sop, sop_pos[3], eop, eop_pos[6], exp_vld, exp_len[16]}
  localparam logic [29:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,3'd0,1'b0,6'd0 ,1'b0,16'd0  },  // R1 idle
    {1'b1,1'b1,1'b1,3'd2,1'b0,6'd0 ,1'b0,16'd0  },  // R2 start 48
    {1'b1,1'b1,1'b0,3'd0,1'b0,6'd0 ,1'b0,16'd0  },  // R3 middle 64
    {1'b1,1'b0,1'b0,3'd0,1'b1,6'd5 ,1'b0,16'd0  },  // R1 stalled end
    {1'b1,1'b1,1'b1,3'd2,1'b1,6'd12,1'b1,16'd125},  // R6 split
    {1'b1,1'b1,1'b0,3'd0,1'b1,6'd31,1'b1,16'd80 },  // R4 48+32
    {1'b1,1'b1,1'b1,3'd1,1'b1,6'd20,1'b1,16'd13 },  // R5 single
    {1'b1,1'b1,1'b0,3'd0,1'b1,6'd9 ,1'b0,16'd0  },  // R7 orphan end
    {1'b1,1'b1,1'b0,3'd0,1'b0,6'd0 ,1'b0,16'd0  },  // R7 gap word
    {1'b1,1'b1,1'b1,3'd0,1'b0,6'd0 ,1'b0,16'd0  },  // R2 start 64
    {1'b0,1'b1,1'b0,3'd0,1'b1,6'd0 ,1'b0,16'd0  },  // R1 no source
    {1'b1,1'b1,1'b0,3'd0,1'b1,6'd0 ,1'b1,16'd65 },  // R4 64+1
    {1'b1,1'b1,1'b1,3'd7,1'b1,6'd63,1'b1,16'd8  },  // R5 top slice
    {1'b1,1'b1,1'b1,3'd7,1'b0,6'd0 ,1'b0,16'd0  },  // R2 start 8
    {1'b1,1'b1,1'b1,3'd1,1'b1,6'd7 ,1'b1,16'd16 },  // R6 boundary split
    {1'b1,1'b1,1'b0,3'd0,1'b1,6'd63,1'b1,16'd120},  // R6 56+64
    {1'b0,1'b0,1'b0,3'd0,1'b0,6'd0 ,1'b0,16'd0  }   // R9 strobe drops
  };

  task automatic check(input string req, input logic av, input logic [LEN_W-1:0] al,
                       input logic ev, input logic [LEN_W-1:0] el);
    runs++;
    if (av !== ev || (ev && al !== el)) begin
      fails++;
      $display("FAIL %s: vld=%0b len=%0d expected vld=%0b len=%0d", req, av, al, ev, el);
    end
  endtask

  task automatic drive(input logic s, d, so, input logic [POS_W-1:0] p,
                       input logic eo, input logic [EW-1:0] e);
    src = s; dst = d; sop = so; sp = p; eop = eo; ep = e;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R8 reset", len_vld, len_out, 1'b0, '0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][29], VEC[i][28], VEC[i][27], VEC[i][26:24], VEC[i][23], VEC[i][22:17]);
      @(negedge clk);
      check($sformatf("R%0s vec %0d", "1-9", i), len_vld, len_out, VEC[i][16], VEC[i][15:0]);
    end
    // R8: reset in mid-packet discards it
    drive(1, 1, 1, 3'd0, 0, '0);
    @(negedge clk);
    drive(0, 0, 0, 3'd0, 0, '0);
    rst_n = 0;
    @(negedge clk);
    check("R8 in reset", len_vld, len_out, 1'b0, '0);
    rst_n = 1;
    drive(1, 1, 0, 3'd0, 1, 6'd3);
    @(negedge clk);
    check("R8 open dropped", len_vld, len_out, 1'b0, '0);
    // R9: back-to-back single-word packets keep strobe high two cycles
    drive(1, 1, 1, 3'd0, 1, 6'd4);
    @(negedge clk);
    check("R9 first", len_vld, len_out, 1'b1, 16'd5);
    drive(1, 1, 1, 3'd4, 1, 6'd40);
    @(negedge clk);
    check("R9 second", len_vld, len_out, 1'b1, 16'd9);
    drive(0, 0, 0, 3'd0, 0, '0);
    @(negedge clk);
    check("R9 drop", len_vld, len_out, 1'b0, '0);
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    runs++;
    $display("FAIL watchdog: vld=%0b len=%0d expected completion", len_vld, len_out);
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule